// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block owns the driver-enable line of an RS-485 transceiver that sits behind a UART. When automatic mode is on, the block turns the line on as soon as the UART transmitter reports that it is busy. It keeps the line on while the frame is shifted out. When the transmitter goes idle, it keeps the line on for a programmed number of bit periods and then turns it off. This gives the far end time to see the last stop bit before the bus is released.

A single configuration word sets the behaviour:

- an automatic-mode enable;
- a hardware-ownership select that takes the pin away from software;
- a polarity select for transceivers whose enable is active-low;
- a 4-bit turnaround delay counted in bit periods.

When hardware does not own the pin, it follows the request-to-send bit from the modem-control logic. The block adds no lead time before the first start bit. Its only timing inputs are the transmitter busy level and the once-per-bit tick from the UART core.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the configuration word reads 0 and the pin output equals the software request-to-send input.
- R2: A write strobe loads the whole configuration word, which reads back unchanged from the next cycle. Field positions: bit 0 is auto enable, bit 1 is hardware ownership, bit 2 is polarity, and bits 11:8 are the turnaround delay.
- R3: With bits 0 and 1 both clear, the pin equals the software request-to-send input in every cycle.
- R4: With bit 0 or bit 1 set, changes of the software request-to-send input have no effect on the pin.
- R5: With auto enable set, the pin takes its active level in the same cycle that transmitter busy is high, with no lead delay. The active level is high when polarity is 0 and low when polarity is 1.
- R6: After transmitter busy falls, bit ticks are counted from the following cycle. With delay N the pin stays active through the clock edge of the (N+1)th counted tick and reaches its idle level in the cycle after that edge.
- R7: With delay 0 the pin is released on the first counted bit tick after transmission completes.
- R8: If transmitter busy rises again during the countdown, the countdown is abandoned, the pin stays active, and a full new countdown starts when busy next falls.
- R9: With hardware ownership set and auto enable clear, the pin stays at its idle level (equal to the polarity bit) even while the transmitter is busy.
- R10: Clearing auto enable during a countdown ends it: the pin returns to software control, and when auto mode is re-enabled the pin is at its idle level.
- R11: Bit ticks that arrive while the transmitter is busy do not shorten the later countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | CFG_W (16) | Configuration write value |
| cfg_rd_data | output | CFG_W (16) | Configuration readback |
| sw_rts | input | 1 | Software request-to-send level from modem control |
| tx_busy | input | 1 | High while the shift register or the transmit FIFO holds data |
| bit_tick | input | 1 | One-cycle strobe once per bit period |
| rts_pin | output | 1 | Transceiver direction pin level |

## Verification
A wrong countdown value or a stuck hold state shows up as a release that comes one or more bit ticks early or late. This can be seen at the pin within at most sixteen ticks of the end of transmission. A state machine left in its send or hold state after auto mode is disabled shows as a pin stuck at its active level when auto mode comes back. A wrong ownership decode shows in the same cycle that software request-to-send toggles. The bench sweeps both polarities and all sixteen delays, and compares the pin against an arithmetic tick-count model in every cycle.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
   localparam int AUTO_EN_BIT = 0;
   localparam int HW_OWN_BIT  = 1;
   localparam int POL_BIT     = 2;
   localparam int DLY_LSB     = 8;

   typedef enum logic [1:0] {
      DIR_IDLE = 2'd0,
      DIR_SEND = 2'd1,
      DIR_HOLD = 2'd2
   } dir_state_e;
endpackage

// File: rtl/rs485_cfg_reg.sv
module rs485_cfg_reg
   import rs485_dir_pkg::*;
#(
   parameter int CFG_W = 16,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] rd_data,
   output logic             auto_en,
   output logic             hw_own,
   output logic             pol,
   output logic [DLY_W-1:0] dly
);
   localparam int DLY_MSB = DLY_LSB + DLY_W - 1;

   if (DLY_MSB >= CFG_W) begin : g_bad_width
      $error("delay field does not fit in configuration word");
   end

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_en) cfg_q <= wr_data;
   end

   assign rd_data = cfg_q;
   assign auto_en = cfg_q[AUTO_EN_BIT];
   assign hw_own  = cfg_q[HW_OWN_BIT];
   assign pol     = cfg_q[POL_BIT];
   assign dly     = cfg_q[DLY_MSB:DLY_LSB];

   // R2: a write is visible on the next cycle
   a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data));
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
   import rs485_dir_pkg::*;
#(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tx_busy,
   input  logic             bit_tick,
   input  logic [DLY_W-1:0] dly,
   output logic             dir_active
);
   dir_state_e       state;
   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         state <= DIR_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            DIR_IDLE: if (tx_busy) state <= DIR_SEND;
            DIR_SEND: if (!tx_busy) begin
               state <= DIR_HOLD;
               cnt   <= dly;
            end
            DIR_HOLD: begin
               if (tx_busy) state <= DIR_SEND;
               else if (bit_tick) begin
                  if (cnt == '0) state <= DIR_IDLE;
                  else           cnt   <= cnt - 1'b1;
               end
            end
            default: state <= DIR_IDLE;
         endcase
      end
   end

   assign dir_active = en && (tx_busy || state != DIR_IDLE);

   // R6: countdown is loaded when the transmitter goes idle
   a_r6_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DIR_SEND && en && !tx_busy) |=> (state == DIR_HOLD && cnt == $past(dly)));
   // R6: each tick in hold takes one off the count
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DIR_HOLD && en && !tx_busy && bit_tick && cnt != '0)
      |=> (state == DIR_HOLD && cnt == $past(cnt) - 1'b1));
   // R7: an exhausted count releases on the tick
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DIR_HOLD && en && !tx_busy && bit_tick && cnt == '0) |=> state == DIR_IDLE);
   // R8: new data during hold returns to send
   a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DIR_HOLD && en && tx_busy) |=> state == DIR_SEND);
   // R10: disabling forces idle
   a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == DIR_IDLE);
endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux (
   input  logic auto_en,
   input  logic hw_own,
   input  logic pol,
   input  logic dir_active,
   input  logic sw_rts,
   output logic pin_d
);
   always_comb begin
      if (auto_en || hw_own) pin_d = dir_active ^ pol;
      else                   pin_d = sw_rts;
   end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
   import rs485_dir_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int DLY_W   = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   output logic [CFG_W-1:0] cfg_rd_data,
   input  logic             sw_rts,
   input  logic             tx_busy,
   input  logic             bit_tick,
   output logic             rts_pin
);
   if (CFG_W < POL_BIT + 1 || DLY_W < 1) begin : g_bad_param
      $error("configuration word too narrow");
   end

   logic             auto_en, hw_own, pol, dir_active, pin_d;
   logic [DLY_W-1:0] dly;

   rs485_cfg_reg #(.CFG_W(CFG_W), .DLY_W(DLY_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
      .rd_data(cfg_rd_data), .auto_en(auto_en), .hw_own(hw_own),
      .pol(pol), .dly(dly));

   rs485_dir_fsm #(.DLY_W(DLY_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .en(auto_en), .tx_busy(tx_busy),
      .bit_tick(bit_tick), .dly(dly), .dir_active(dir_active));

   rs485_pin_mux mux_i (
      .auto_en(auto_en), .hw_own(hw_own), .pol(pol),
      .dir_active(dir_active), .sw_rts(sw_rts), .pin_d(pin_d));

   if (OUT_REG) begin : g_reg_out
      logic pin_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= pin_d;
      end
      assign rts_pin = pin_q;
   end else begin : g_comb_out
      assign rts_pin = pin_d;

      // R4: a software toggle alone cannot move a hardware-owned pin
      a_r4_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         ((auto_en || hw_own) && $stable(dir_active) && $stable(cfg_rd_data))
         |-> (rts_pin == (dir_active ^ pol)));
      // R5: busy with auto mode drives the active level at once
      a_r5_no_lead: assert property (@(posedge clk) disable iff (!rst_n)
         (auto_en && tx_busy) |-> (rts_pin == !pol));
   end
endmodule

// File: tb/rs485_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [15:0] cfg_wr_data = '0;
   logic [15:0] cfg_rd_data;
   logic        sw_rts = 1'b0;
   logic        tx_busy = 1'b0;
   logic        bit_tick = 1'b0;
   logic        rts_pin;

   int checks = 0;
   int failures = 0;

   // bench model
   logic       m_en = 0, m_own = 0, m_pol = 0;
   int         m_dly = 0;
   logic       seen = 0, hold = 0;
   int         ticks = 0;

   always #4 clk = ~clk;

   rs485_dir_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(cfg_rd_data), .sw_rts(sw_rts), .tx_busy(tx_busy),
      .bit_tick(bit_tick), .rts_pin(rts_pin));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_pin(input logic b, input logic sw);
      logic act;
      act = m_en & (b | seen);
      return (m_en | m_own) ? (act ^ m_pol) : sw;
   endfunction

   task automatic model_update(input logic b, input logic t);
      if (!m_en) begin
         seen = 0; hold = 0; ticks = 0;
      end else if (b) begin
         seen = 1; hold = 0; ticks = 0;
      end else if (seen && !hold) begin
         hold = 1;
      end else if (hold && t) begin
         ticks++;
         if (ticks == m_dly + 1) begin seen = 0; hold = 0; end
      end
   endtask

   task automatic step(input logic b, input logic t, input logic sw, input string req);
      @(negedge clk);
      tx_busy = b; bit_tick = t; sw_rts = sw;
      #1;
      chk(req, {15'd0, rts_pin}, {15'd0, exp_pin(b, sw)});
      @(posedge clk);
      model_update(b, t);
   endtask

   task automatic wr_cfg(input logic en, input logic own, input logic pol, input int dly);
      logic [15:0] w;
      w = '0;
      w[0] = en; w[1] = own; w[2] = pol; w[11:8] = dly[3:0];
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_data = w; tx_busy = 1'b0; bit_tick = 1'b0;
      @(posedge clk);
      model_update(1'b0, 1'b0);
      m_en = en; m_own = own; m_pol = pol; m_dly = dly;
      if (!en) begin seen = 0; hold = 0; end
      @(negedge clk);
      cfg_wr_en = 1'b0;
      #1;
      chk("R2", cfg_rd_data, w);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", cfg_rd_data, 16'h0000);
      step(0, 0, 1, "R1");
      step(0, 0, 0, "R1");
      // R3: disabled passthrough, busy has no effect
      for (int i = 0; i < 8; i++) step(i[1], i[0], i[2], "R3");

      // R5 R6 R7 R11 R4: sweep polarity and every delay
      for (int p = 0; p < 2; p++) begin
         for (int d = 0; d < 16; d++) begin
            wr_cfg(1, 0, p[0], d);
            for (int i = 0; i < 6; i++) step(1, (i % 3) == 2, i[0], "R5");
            for (int i = 0; i < 2 * d + 8; i++)
               step(0, i[0], i[1], (d == 0) ? "R7" : "R6");
         end
      end

      // R8: restart during countdown
      wr_cfg(1, 0, 0, 3);
      for (int i = 0; i < 3; i++) step(1, 0, 0, "R8");
      for (int i = 0; i < 3; i++) step(0, 1, 0, "R8");
      for (int i = 0; i < 2; i++) step(1, 0, 0, "R8");
      for (int i = 0; i < 8; i++) step(0, 1, 0, "R8");

      // R11: ticks while sending are not counted
      wr_cfg(1, 0, 1, 2);
      for (int i = 0; i < 4; i++) step(1, 1, 1, "R11");
      for (int i = 0; i < 5; i++) step(0, 0, 0, "R11");
      for (int i = 0; i < 6; i++) step(0, 1, 1, "R11");

      // R10: disable mid-countdown, then re-enable
      wr_cfg(1, 0, 0, 15);
      step(1, 0, 0, "R10");
      step(1, 0, 0, "R10");
      step(0, 1, 0, "R10");
      step(0, 1, 0, "R10");
      wr_cfg(0, 0, 0, 15);
      step(0, 0, 1, "R10");
      step(0, 0, 0, "R10");
      wr_cfg(1, 0, 0, 15);
      step(0, 0, 1, "R10");
      step(0, 1, 0, "R10");

      // R9: ownership without auto mode holds idle level
      wr_cfg(0, 1, 1, 4);
      for (int i = 0; i < 6; i++) step(i < 3, i[0], i[0], "R9");
      wr_cfg(0, 1, 0, 4);
      for (int i = 0; i < 4; i++) step(1, 0, i[0], "R4");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule